// File: doc/BRIEF.md
# Reloading Interval Timer Channel

This block is one programmable interval timer. A 32-bit counter steps down by one on each prescaled tick while the channel runs. A tick that finds the counter at zero is an underflow. On an underflow the counter reloads from a 32-bit reload register and keeps counting, so the channel produces a fixed period without software help. The tick comes from the module clock through a prescaler. A 3-bit code in the control register selects the divide ratio.

Each underflow sets a sticky event flag. Software clears the flag by writing zero to its bit. A separate enable bit gates the flag onto a level-sensitive interrupt line. Software can read the live count at any time and can test the flag to find an underflow that happened between two reads. Registers are reached through a plain word-wide write/address bus. Writes take effect at the clock edge, and reads are combinational from the address.

Top module: `rtimer_chan`

## Requirements
- R1: After synchronous reset every register reads zero, the channel is halted and `irq` is low.
- R2: While running, the count drops by exactly one per prescaled tick. While halted, it holds its value.
- R3: For prescale code c in 0..3 a tick occurs every 4 << (2·c) module clocks (4, 16, 64, 256). The first tick after a start comes that many clocks after the start write.
- R4: Codes 4..7 divide by 4. A control write that changes the code restarts the divider, so the next tick comes a full new period after that write.
- R5: A tick at count zero loads the count from the reload register and sets the flag at control bit 8.
- R6: The flag stays set until a control write with bit 8 = 0. A write with bit 8 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R7: `irq` is high exactly when the flag is set and control bit 5 (interrupt enable) is set. With bit 5 clear the channel still counts and sets the flag.
- R8: Writes to the count and reload registers are ignored while the channel runs and take effect while it is halted.
- R9: Address map: 0 = start (bit 0 runs/halts), 1 = reload, 2 = count, 3 = control (bits 2:0 code, bit 5 enable, bit 8 flag). Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register select for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Level interrupt: flag AND enable |

## Verification
The period between successive count changes is measured for each legal prescale code and for one reserved code, which tells the four ratios and the /4 fallback apart. A code change issued mid-period is timed to the next tick, which separates a restarting divider from one that carries on. Continuous clearing writes over a stream of underflows every four clocks show whether set wins over clear. Runs with the enable set and with it clear show that the flag and the interrupt are distinct. A behavioural model compares the selected register and the interrupt on every clock, so that any drift in the reload timing or in write blocking shows up in the cycle where it occurs.

// File: rtl/rtimer_pkg.sv
`timescale 1ns/1ps
package rtimer_pkg;

    localparam int CNT_W    = 32;
    localparam int ADDR_W   = 2;
    localparam int CODE_W   = 3;
    localparam int MAX_CODE = 3;
    localparam int DIV_W    = 2 + 2 * MAX_CODE;
    localparam int IE_BIT   = 5;
    localparam int FLAG_BIT = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_START = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              flag;
        logic              ie;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    // Last divider state of a period: ratio minus one; reserved codes use /4.
    function automatic int div_last(input logic [CODE_W-1:0] code);
        int r;
        if (int'(code) > MAX_CODE) r = 4;
        else                       r = 4 << (2 * int'(code));
        return r - 1;
    endfunction

endpackage

// File: rtl/rtimer_prescale.sv
`timescale 1ns/1ps
module rtimer_prescale #(
    parameter int DIV_W  = rtimer_pkg::DIV_W,
    parameter int CODE_W = rtimer_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;

    always_comb last = DIV_W'(rtimer_pkg::div_last(code));

    assign tick = run && (div_q == last);

    always_ff @(posedge clk) begin
        if (rst)                       div_q <= '0;
        else if (!run || restart || tick) div_q <= '0;
        else                           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/rtimer_count.sv
`timescale 1ns/1ps
module rtimer_count #(
    parameter int CNT_W = rtimer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             underflow
);
    assign underflow = tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (underflow) cnt <= reload_val;
        else if (tick)      cnt <= cnt - 1'b1;
        else if (ld_en)     cnt <= ld_val;
    end
endmodule

// File: rtl/rtimer_regs.sv
`timescale 1ns/1ps
module rtimer_regs
    import rtimer_pkg::*;
#(
    parameter int CNT_W  = rtimer_pkg::CNT_W,
    parameter int ADDR_W = rtimer_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              underflow,
    output logic              run,
    output logic [CNT_W-1:0]  reload_val,
    output ctrl_t             ctrl,
    output logic              cnt_ld,
    output logic              restart,
    output logic              irq,
    output logic [CNT_W-1:0]  bus_rdata
);
    reg_sel_e sel;
    logic     wr_start, wr_reload, wr_ctrl;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_start  = bus_wr && (sel == REG_START);
    assign wr_reload = bus_wr && (sel == REG_RELOAD) && !run;
    assign wr_ctrl   = bus_wr && (sel == REG_CTRL);
    assign cnt_ld    = bus_wr && (sel == REG_COUNT) && !run;
    assign restart   = wr_ctrl && (bus_wdata[CODE_W-1:0] != ctrl.code);
    assign irq       = ctrl.flag && ctrl.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            run        <= 1'b0;
            reload_val <= '0;
            ctrl       <= '0;
        end else begin
            if (wr_start)  run        <= bus_wdata[0];
            if (wr_reload) reload_val <= bus_wdata;
            if (wr_ctrl) begin
                ctrl.code <= bus_wdata[CODE_W-1:0];
                ctrl.ie   <= bus_wdata[IE_BIT];
            end
            if (underflow)                       ctrl.flag <= 1'b1;
            else if (wr_ctrl && !bus_wdata[FLAG_BIT]) ctrl.flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_START:  bus_rdata[0] = run;
            REG_RELOAD: bus_rdata    = reload_val;
            REG_COUNT:  bus_rdata    = cnt;
            REG_CTRL: begin
                bus_rdata[CODE_W-1:0] = ctrl.code;
                bus_rdata[IE_BIT]     = ctrl.ie;
                bus_rdata[FLAG_BIT]   = ctrl.flag;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtimer_chan.sv
`timescale 1ns/1ps
module rtimer_chan
    import rtimer_pkg::*;
#(
    parameter int CNT_W  = rtimer_pkg::CNT_W,
    parameter int ADDR_W = rtimer_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic             run_w, tick_w, uf_w, ld_w, restart_w;
    logic [CNT_W-1:0] cnt_w, reload_w;
    ctrl_t            ctrl_w;
    logic             flag_w, ie_w;

    assign flag_w = ctrl_w.flag;
    assign ie_w   = ctrl_w.ie;

    rtimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt(cnt_w), .underflow(uf_w),
        .run(run_w), .reload_val(reload_w), .ctrl(ctrl_w),
        .cnt_ld(ld_w), .restart(restart_w), .irq(irq),
        .bus_rdata(bus_rdata)
    );

    rtimer_prescale #(.DIV_W(DIV_W), .CODE_W(CODE_W)) u_pre (
        .clk(clk), .rst(rst), .run(run_w), .restart(restart_w),
        .code(ctrl_w.code), .tick(tick_w)
    );

    rtimer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_w), .ld_en(ld_w),
        .ld_val(bus_wdata), .reload_val(reload_w),
        .cnt(cnt_w), .underflow(uf_w)
    );
endmodule

// File: rtl/rtimer_chan_chk.sv
`timescale 1ns/1ps
module rtimer_chan_chk #(
    parameter int CNT_W  = rtimer_pkg::CNT_W,
    parameter int ADDR_W = rtimer_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              run,
    input logic              tick,
    input logic              uf,
    input logic              ld_en,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              flag,
    input logic              ie,
    input logic              irq
);
    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == 2'd3) && !bus_wdata[rtimer_pkg::FLAG_BIT];

    a_r2_hold_halted: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld_en) |=> $stable(cnt));

    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r3_no_tick_halted: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

    a_r5_reload_sets_flag: assert property (@(posedge clk) disable iff (rst)
        uf |=> (cnt == $past(reload) && flag));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_wr) |=> flag);

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq);

    a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (flag && ie) |-> irq);

    a_r8_no_load_running: assert property (@(posedge clk) disable iff (rst)
        run |-> !ld_en);
endmodule

bind rtimer_chan rtimer_chan_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .run(run_w), .tick(tick_w), .uf(uf_w),
    .ld_en(ld_w), .cnt(cnt_w), .reload(reload_w), .flag(flag_w),
    .ie(ie_w), .irq(irq)
);

// File: tb/test_rtimer_chan.sv
`timescale 1ns/1ps
module test_rtimer_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rtimer_chan i_rtimer_chan (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_cnt, m_rel;
    logic        m_run, m_ie, m_flag;
    logic [2:0]  m_code;
    int          m_div;

    function automatic int ratio_of(input logic [2:0] c);
        if (c > 3'd3) return 4;
        return 4 << (2 * int'(c));
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            2'd0: v[0] = m_run;
            2'd1: v = m_rel;
            2'd2: v = m_cnt;
            default: begin v[2:0] = m_code; v[5] = m_ie; v[8] = m_flag; end
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_rel = '0; m_run = 0; m_ie = 0; m_flag = 0; m_code = '0; m_div = 0;
        end else begin
            bit tk, uf, wc, chg;
            tk  = m_run && (m_div == ratio_of(m_code) - 1);
            uf  = tk && (m_cnt == 0);
            wc  = bus_wr && bus_addr == 2'd3;
            chg = wc && (bus_wdata[2:0] != m_code);
            if (!m_run || chg || tk) m_div = 0; else m_div = m_div + 1;
            if (uf)      m_cnt = m_rel;
            else if (tk) m_cnt = m_cnt - 1;
            else if (!m_run && bus_wr && bus_addr == 2'd2) m_cnt = bus_wdata;
            if (!m_run && bus_wr && bus_addr == 2'd1) m_rel = bus_wdata;
            if (uf) m_flag = 1'b1;
            else if (wc && !bus_wdata[8]) m_flag = 1'b0;
            if (wc) begin m_code = bus_wdata[2:0]; m_ie = bus_wdata[5]; end
            if (bus_wr && bus_addr == 2'd0) m_run = bus_wdata[0];
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (bus_rdata !== m_read(bus_addr)) begin
                fails++;
                $display("FAIL R2 per-cycle rdata addr=%0d actual=%h expected=%h",
                         bus_addr, bus_rdata, m_read(bus_addr));
            end
            tests++;
            if (irq !== (m_flag && m_ie)) begin
                fails++;
                $display("FAIL R7 per-cycle irq actual=%0b expected=%0b", irq, m_flag && m_ie);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 2'd2;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        #1 bus_addr = 2'd2;
    endtask

    task automatic measure(output int cyc);
        logic [31:0] v;
        int n;
        @(negedge clk); v = bus_rdata; n = 0;
        while (bus_rdata == v && n < 2000) begin @(negedge clk); n++; end
        v = bus_rdata; n = 0;
        do begin @(negedge clk); n++; end while (bus_rdata == v && n < 2000);
        cyc = n;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v, v2;
        int cyc, seen;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R9: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check($sformatf("R1 reset value of register %0d", a), v, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R8 / R9: halted loads and control readback
        wr(2'd1, 32'h40);
        wr(2'd2, 32'h40);
        rd(2'd1, v); check("R8 reload accepted while halted", v, 32'h40);
        rd(2'd2, v); check("R8 count accepted while halted", v, 32'h40);
        wr(2'd3, 32'hFFFF_FEFF);
        rd(2'd3, v); check("R9 control unused bits read zero", v, 32'h0000_0027);

        // R3 / R4: tick period per code
        for (int c = 0; c < 5; c++) begin
            logic [2:0] code;
            code = (c == 4) ? 3'd6 : 3'(c);
            wr(2'd3, {29'b0, code});
            wr(2'd0, 32'h1);
            measure(cyc);
            check($sformatf("R3 R4 period for code %0d", code), cyc, ratio_of(code));
            wr(2'd0, 32'h0);
        end

        // R2: halted count holds
        rd(2'd2, v);
        repeat (50) @(posedge clk);
        rd(2'd2, v2);
        check("R2 count holds while halted", v2, v);

        // R4: code change restarts the divider
        wr(2'd3, 32'h1);
        wr(2'd0, 32'h1);
        measure(cyc);
        repeat (10) @(posedge clk);
        wr(2'd3, 32'h0);
        #0.1 v = bus_rdata; cyc = 0;
        do begin @(negedge clk); cyc++; end while (bus_rdata == v && cyc < 500);
        check("R4 restart: cycles from code write to next tick", cyc, 5);
        wr(2'd0, 32'h0);

        // R5 / R7: underflow, reload, flag and irq
        wr(2'd2, 32'h2);
        wr(2'd1, 32'h9);
        wr(2'd3, 32'h20);
        wr(2'd0, 32'h1);
        repeat (20) @(posedge clk);
        wr(2'd0, 32'h0);
        rd(2'd3, v); check("R5 flag set by underflow", v, 32'h120);
        check("R7 irq high with flag and enable", {31'b0, irq}, 32'h1);
        rd(2'd2, v); check("R5 count reloaded from reload register", v, m_cnt);

        // R6: write-one keeps, write-zero clears
        wr(2'd3, 32'h120);
        rd(2'd3, v); check("R6 writing 1 to flag keeps it", v, 32'h120);
        wr(2'd3, 32'h20);
        rd(2'd3, v); check("R6 writing 0 clears flag", v, 32'h20);
        check("R7 irq drops with flag", {31'b0, irq}, 32'h0);

        // R7: enable clear -> flag but no irq
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h1);
        repeat (60) @(posedge clk);
        rd(2'd3, v); check("R7 flag set with enable clear", v, 32'h100);
        check("R7 irq stays low with enable clear", {31'b0, irq}, 32'h0);

        // R8: loads ignored while running
        wr(2'd2, 32'h1234);
        rd(2'd2, v);
        check("R8 count write ignored while running", v, m_cnt);
        wr(2'd1, 32'h77);
        rd(2'd1, v); check("R8 reload write ignored while running", v, 32'h9);
        wr(2'd0, 32'h0);

        // R6: set wins over simultaneous clear
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd3, 32'h20);
        wr(2'd0, 32'h1);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h20;
        seen = 0;
        repeat (16) begin @(negedge clk); if (bus_rdata[8]) seen++; end
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 2'd2;
        check("R6 set wins over clear (flag observed)", {31'b0, seen >= 3}, 32'h1);
        wr(2'd0, 32'h0);

        repeat (5) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule